// File: doc/BRIEF.md
# Power-Fail Gated Bank Chip-Enable Decoder

This block steers one active-low chip-enable onto one of several active-low bank enables, picking the bank from a small binary select. It is meant to sit between a processor's memory strobe and a set of static RAM banks that must keep their contents through a supply loss. A digitized power-fail flag, produced elsewhere by a supply comparator, tells the block when the supply has left its valid range. From then on every bank is write-protected.

An access that is already under way when the flag rises may finish. This grace period is bounded: once it runs out, every bank is shut off. A new access that starts while the flag is high is never forwarded. When the flag falls again, all bank enables stay inactive for a recovery interval so the processor can settle, and only then does the strobe pass through again. Both intervals are counted in clock cycles and set by parameters. The same recovery interval also runs after reset, before the first access is forwarded.

The select path and the strobe path are combinational while the gate is open. Only the gating state is registered.

Top module: `pwrgate_top`

## Requirements
- R1: While ce_n_in is high, every bit of bank_ce_n is high, for any bank_sel and any internal state.
- R2: In normal operation with ce_n_in low, bank_ce_n[k] is low where k is the unsigned value of bank_sel. Bit 0 of bank_sel is the first decode input and bit 1 the second, so 00 selects bank 0, 01 bank 1, 10 bank 2 and 11 bank 3. Every other bit stays high.
- R3: At most one bit of bank_ce_n is low in any cycle.
- R4: If pwr_fail is sampled high at a clock edge while ce_n_in is also high, every bank enable is high from that edge on, for as long as pwr_fail stays high.
- R5: If pwr_fail is first sampled high while ce_n_in is low, the bank selected at that edge keeps driving ce_n_in while ce_n_in stays low, even if bank_sel changes. Once ce_n_in has been sampled high, the access is over.
- R6: A held access lasts for at most WPT_CYCLES clock edges after the edge that first saw pwr_fail high. After that, every bank enable is forced high unconditionally.
- R7: While pwr_fail stays high, a strobe that falls after the held access has ended, or after a fault that began with no access, is never forwarded.
- R8: After pwr_fail is first sampled low, every bank enable stays high for REC_CYCLES further clock edges, whatever ce_n_in does. Forwarding then resumes.
- R9: If pwr_fail is sampled high during the recovery interval, the interval restarts from zero after pwr_fail falls again.
- R10: During reset every bank enable is high. After reset, the block behaves as if the supply had just returned: forwarding begins only after REC_CYCLES + 1 edges with pwr_fail low.
- R11: If pwr_fail falls while an access is being held, the held access ends at that edge and the recovery interval begins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the gating state and interval counters |
| rst_n | input | 1 | Asynchronous active-low reset; enters the write-protected state |
| ce_n_in | input | 1 | Active-low chip-enable strobe from the processor |
| bank_sel | input | SEL_W | Binary bank select, bit 0 being the first decode input |
| pwr_fail | input | 1 | Digitized supply-out-of-range flag, high while power is invalid |
| bank_ce_n | output | NUM_BANKS | Conditioned active-low bank enables |

## Verification
The hardest corner to reach is a power fault that lands in the middle of a strobe. Reaching it also means moving the select during the hold, letting the strobe run past the timeout, and in a separate case dropping the fault flag before the strobe ends. The stimulus first brings the gate open through a full recovery interval. It then holds ce_n_in low and raises pwr_fail for one edge, and drives each variant on purpose: bank_sel swapped during the hold, the strobe released and lowered again, the strobe kept low for twice WPT_CYCLES, and pwr_fail released before the strobe. A second phase injects a one-cycle fault pulse in the middle of recovery. A long pseudo-random run then mixes rare fault toggles with dense strobe activity, and a behavioural model in the bench is checked against the outputs on every cycle.

// File: rtl/pwrgate_pkg.sv
package pwrgate_pkg;

   // Gating state of the conditioned enable path.
   typedef enum logic [1:0] {
      ST_LOCK    = 2'd0,  // power invalid, all banks protected
      ST_RECOVER = 2'd1,  // power valid, recovery interval running
      ST_PASS    = 2'd2,  // strobe forwarded to the selected bank
      ST_DRAIN   = 2'd3   // fault seen mid-access, finishing that access
   } gate_state_t;

   // Width of a counter that must hold values 0..limit.
   function automatic int cnt_width(input int limit);
      return (limit < 1) ? 1 : $clog2(limit + 1);
   endfunction

endpackage

// File: rtl/pwrgate_cycle_timer.sv
module pwrgate_cycle_timer
   import pwrgate_pkg::*;
#(
   parameter int LIMIT = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear,
   input  logic advance,
   output logic last
);

   localparam int CW = cnt_width(LIMIT);
   localparam logic [CW-1:0] LAST_VAL = CW'(LIMIT - 1);

   logic [CW-1:0] count_q;

   generate
      if (LIMIT < 1) begin : g_bad_limit
         $error("pwrgate_cycle_timer: LIMIT must be at least 1");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count_q <= '0;
      end else if (clear) begin
         count_q <= '0;
      end else if (advance && (count_q != LAST_VAL)) begin
         count_q <= count_q + CW'(1);
      end
   end

   assign last = (count_q == LAST_VAL);

endmodule

// File: rtl/pwrgate_bank_decoder.sv
module pwrgate_bank_decoder #(
   parameter int SEL_W     = 2,
   parameter int NUM_BANKS = 4
) (
   input  logic                 ce_n,
   input  logic                 grant,
   input  logic [SEL_W-1:0]     route_sel,
   output logic [NUM_BANKS-1:0] bank_ce_n
);

   logic strobe_on;
   assign strobe_on = grant && !ce_n;

   generate
      for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
         assign bank_ce_n[b] = !(strobe_on && (route_sel == SEL_W'(b)));
      end
   endgenerate

endmodule

// File: rtl/pwrgate_ctrl.sv
module pwrgate_ctrl
   import pwrgate_pkg::*;
#(
   parameter int SEL_W      = 2,
   parameter int WPT_CYCLES = 8,
   parameter int REC_CYCLES = 20
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pwr_fail,
   input  logic             ce_n,
   input  logic [SEL_W-1:0] sel,
   output logic             grant,
   output logic [SEL_W-1:0] route_sel
);

   gate_state_t      state_q, state_d;
   logic [SEL_W-1:0] held_sel_q;
   logic             rec_last, wpt_last;
   logic             in_recover, in_drain;

   assign in_recover = (state_q == ST_RECOVER);
   assign in_drain   = (state_q == ST_DRAIN);

   pwrgate_cycle_timer #(.LIMIT(REC_CYCLES)) i_rec_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear   (!in_recover),
      .advance (in_recover && !pwr_fail),
      .last    (rec_last)
   );

   pwrgate_cycle_timer #(.LIMIT(WPT_CYCLES)) i_wpt_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear   (!in_drain),
      .advance (in_drain),
      .last    (wpt_last)
   );

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_LOCK: begin
            if (!pwr_fail) state_d = ST_RECOVER;
         end
         ST_RECOVER: begin
            if (pwr_fail)      state_d = ST_LOCK;
            else if (rec_last) state_d = ST_PASS;
         end
         ST_PASS: begin
            if (pwr_fail) state_d = ce_n ? ST_LOCK : ST_DRAIN;
         end
         ST_DRAIN: begin
            if (!pwr_fail)          state_d = ST_RECOVER;
            else if (ce_n || wpt_last) state_d = ST_LOCK;
         end
         default: state_d = ST_LOCK;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= ST_LOCK;
         held_sel_q <= '0;
      end else begin
         state_q <= state_d;
         if (state_q == ST_PASS && state_d == ST_DRAIN) begin
            held_sel_q <= sel;
         end
      end
   end

   assign grant     = (state_q == ST_PASS) || (in_drain && pwr_fail);
   assign route_sel = in_drain ? held_sel_q : sel;

endmodule

// File: rtl/pwrgate_top.sv
module pwrgate_top #(
   parameter int SEL_W      = 2,
   parameter int NUM_BANKS  = 4,
   parameter int WPT_CYCLES = 8,
   parameter int REC_CYCLES = 20
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 ce_n_in,
   input  logic [SEL_W-1:0]     bank_sel,
   input  logic                 pwr_fail,
   output logic [NUM_BANKS-1:0] bank_ce_n
);

   generate
      if (SEL_W < 1) begin : g_bad_sel
         $error("pwrgate_top: SEL_W must be at least 1");
      end
      if (NUM_BANKS < 1 || NUM_BANKS > (1 << SEL_W)) begin : g_bad_banks
         $error("pwrgate_top: NUM_BANKS must lie in 1..2**SEL_W");
      end
      if (WPT_CYCLES < 1 || REC_CYCLES < 1) begin : g_bad_times
         $error("pwrgate_top: interval parameters must be at least 1");
      end
   endgenerate

   logic             grant;
   logic [SEL_W-1:0] route_sel;

   pwrgate_ctrl #(
      .SEL_W      (SEL_W),
      .WPT_CYCLES (WPT_CYCLES),
      .REC_CYCLES (REC_CYCLES)
   ) i_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .pwr_fail  (pwr_fail),
      .ce_n      (ce_n_in),
      .sel       (bank_sel),
      .grant     (grant),
      .route_sel (route_sel)
   );

   pwrgate_bank_decoder #(
      .SEL_W     (SEL_W),
      .NUM_BANKS (NUM_BANKS)
   ) i_decoder (
      .ce_n      (ce_n_in),
      .grant     (grant),
      .route_sel (route_sel),
      .bank_ce_n (bank_ce_n)
   );

endmodule

// File: rtl/pwrgate_guard.sv
module pwrgate_guard #(
   parameter int SEL_W      = 2,
   parameter int NUM_BANKS  = 4,
   parameter int WPT_CYCLES = 8,
   parameter int REC_CYCLES = 20
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 ce_n_in,
   input logic [SEL_W-1:0]     bank_sel,
   input logic                 pwr_fail,
   input logic [NUM_BANKS-1:0] bank_ce_n
);

   localparam int QW = $clog2(REC_CYCLES + 2);
   localparam int FW = $clog2(WPT_CYCLES + 2);
   localparam logic [QW-1:0] Q_SAT = QW'(REC_CYCLES + 1);
   localparam logic [FW-1:0] F_SAT = FW'(WPT_CYCLES + 1);

   // Edges since pwr_fail was last sampled high (or since reset).
   logic [QW-1:0] good_edges;
   // Consecutive edges with pwr_fail sampled high.
   logic [FW-1:0] bad_edges;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         good_edges <= '0;
         bad_edges  <= '0;
      end else begin
         if (pwr_fail)               good_edges <= '0;
         else if (good_edges != Q_SAT) good_edges <= good_edges + QW'(1);
         if (!pwr_fail)              bad_edges <= '0;
         else if (bad_edges != F_SAT) bad_edges <= bad_edges + FW'(1);
      end
   end

   assert_idle_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
      ce_n_in |-> (&bank_ce_n));

   assert_decode_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (good_edges == Q_SAT && !pwr_fail && !ce_n_in)
      |-> (bank_ce_n == ~(NUM_BANKS'(1) << bank_sel)));

   assert_one_bank_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(~bank_ce_n) <= 1);

   // R4 and R7: a strobe seen high under fault blocks the rest of the fault.
   assert_no_new_access_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(pwr_fail) && $past(ce_n_in) && pwr_fail) |-> (&bank_ce_n));

   assert_timeout_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (bad_edges == F_SAT) |-> (&bank_ce_n));

   assert_recovery_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (good_edges != Q_SAT) && !pwr_fail |-> (&bank_ce_n));

   assert_reset_R10: assert property (@(posedge clk)
      !rst_n |-> (&bank_ce_n));

endmodule

bind pwrgate_top pwrgate_guard #(
   .SEL_W      (SEL_W),
   .NUM_BANKS  (NUM_BANKS),
   .WPT_CYCLES (WPT_CYCLES),
   .REC_CYCLES (REC_CYCLES)
) i_guard (
   .clk       (clk),
   .rst_n     (rst_n),
   .ce_n_in   (ce_n_in),
   .bank_sel  (bank_sel),
   .pwr_fail  (pwr_fail),
   .bank_ce_n (bank_ce_n)
);

// File: tb/test_pwrgate_top.sv
module test_pwrgate_top;

   localparam int SEL_W = 2;
   localparam int NB    = 4;
   localparam int WPT   = 8;
   localparam int REC   = 20;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             ce_n = 1'b1;
   logic             pf = 1'b1;
   logic [SEL_W-1:0] sel = '0;
   logic [NB-1:0]    outs;

   always #4 clk = ~clk;  // 125 MHz

   pwrgate_top #(
      .SEL_W(SEL_W), .NUM_BANKS(NB), .WPT_CYCLES(WPT), .REC_CYCLES(REC)
   ) i_pwrgate_top (
      .clk(clk), .rst_n(rst_n), .ce_n_in(ce_n), .bank_sel(sel),
      .pwr_fail(pf), .bank_ce_n(outs)
   );

   int    checks = 0;
   int    errors = 0;
   int    cycles = 0;
   string phase  = "R10";

   // Behavioural reference: 0 protected, 1 recovering, 2 open, 3 holding.
   int m_mode  = 0;
   int m_count = 0;
   int m_bank  = 0;

   function automatic logic [NB-1:0] model_out();
      if (m_mode == 2) return ce_n ? '1 : ~(NB'(1) << sel);
      if (m_mode == 3) return (!ce_n && pf) ? ~(NB'(1) << m_bank) : '1;
      return '1;
   endfunction

   function automatic string mode_tag();
      case (m_mode)
         0:       return "R4 R7 protected";
         1:       return "R8 recovering";
         2:       return "R1 R2 open";
         default: return "R5 R6 holding";
      endcase
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_mode = 0; m_count = 0;
      end else begin
         case (m_mode)
            0: if (!pf) begin m_mode = 1; m_count = 0; end
            1: begin
               if (pf) m_mode = 0;
               else if (m_count >= REC - 1) m_mode = 2;
               else m_count++;
            end
            2: if (pf) begin
               if (ce_n) m_mode = 0;
               else begin m_mode = 3; m_count = 0; m_bank = int'(sel); end
            end
            default: begin
               if (!pf) begin m_mode = 1; m_count = 0; end
               else if (ce_n || m_count >= WPT - 1) m_mode = 0;
               else m_count++;
            end
         endcase
      end
   end

   task automatic report();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   always @(negedge clk) begin
      logic [NB-1:0] exp_v;
      cycles++;
      exp_v = model_out();
      checks++;
      if (outs !== exp_v) begin
         errors++;
         $display("FAIL %s (%s): bank_ce_n=%b expected %b at cycle %0d",
                  phase, mode_tag(), outs, exp_v, cycles);
      end
      if (cycles > 50000) begin
         errors++;
         $display("FAIL watchdog: cycle count %0d expected below 50000", cycles);
         report();
      end
   end

   task automatic step(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic drive(input logic c, input int s, input logic p);
      ce_n = c; sel = SEL_W'(s); pf = p;
   endtask

   initial begin
      // R10: reset state, then recovery with an eager strobe.
      drive(1'b0, 1, 1'b0);
      step(4);
      rst_n = 1'b1;
      step(REC + 4);
      // R1 and R2: every select with the strobe high and low.
      phase = "R2";
      for (int s = 0; s < NB; s++) begin
         drive(1'b0, s, 1'b0); step(1);
         drive(1'b1, s, 1'b0); step(1);
      end
      phase = "R3";
      for (int s = 0; s < NB * 3; s++) begin drive(s[0], s % NB, 1'b0); step(1); end
      // R4 fault with no access, strobe tries to start; R8 recovery.
      phase = "R4";
      drive(1'b1, 2, 1'b1); step(1);
      drive(1'b0, 2, 1'b1); step(5);
      phase = "R8";
      drive(1'b0, 3, 1'b0); step(REC + 3);
      // R5 held access with moving select, then R7 re-strobe blocked.
      phase = "R5";
      drive(1'b0, 2, 1'b0); step(1);
      drive(1'b0, 2, 1'b1); step(1);
      drive(1'b0, 0, 1'b1); step(2);
      drive(1'b1, 1, 1'b1); step(1);
      phase = "R7";
      drive(1'b0, 1, 1'b1); step(4);
      drive(1'b0, 1, 1'b0); step(REC + 3);
      // R6 strobe kept low through the timeout.
      phase = "R6";
      drive(1'b0, 3, 1'b1); step(WPT * 2 + 2);
      drive(1'b1, 3, 1'b0); step(REC + 3);
      // R9 fault pulse in the middle of recovery.
      phase = "R9";
      drive(1'b1, 0, 1'b1); step(2);
      drive(1'b0, 0, 1'b0); step(REC / 2);
      drive(1'b0, 0, 1'b1); step(1);
      drive(1'b0, 1, 1'b0); step(REC + 3);
      // R11 power returns while an access is held.
      phase = "R11";
      drive(1'b0, 1, 1'b1); step(3);
      drive(1'b0, 1, 1'b0); step(REC + 3);
      // Mixed pseudo-random traffic.
      phase = "R1 R2 R5 R6 R8 random";
      for (int i = 0; i < 3000; i++) begin
         logic p_next;
         p_next = pf;
         if ($urandom_range(0, 59) == 0) p_next = ~pf;
         drive(($urandom_range(0, 2) == 0), $urandom_range(0, NB - 1), p_next);
         step(1);
      end
      report();
   end

endmodule